// File: doc/BRIEF.md
# Timer/Counter and Watchdog with a Shared Prescaler

This block holds an 8-bit timer/counter and a watchdog counter that share one power-of-two prescaler. A mode register controls the timer. It picks the timer's event source, which is the instruction-cycle enable or edges on an external count pin. It also picks which pin edge counts, gives the prescaler either to the timer or to the watchdog, and holds a 3-bit rate field. The same rate field reads as a different divide ratio depending on which side owns the prescaler.

The timer sets a sticky overflow flag each time it wraps from 0xFF to 0x00. That flag becomes an interrupt request when the timer interrupt enable and the global enable are both high. The watchdog is advanced by a tick-enable input, which stands in for the free-running oscillator that normally drives it. When the watchdog wraps, it emits a one-cycle reset pulse. A clear strobe restarts the watchdog.

Software reaches the block through a small write port with three addresses:
- Address 0 is the timer count.
- Address 1 is the mode register.
- Address 2 is the overflow flag.

Top module: `tmr_wdt_shared`

## Requirements
- R1: After reset, the mode register reads 0xFF, the count is 0x00, and the overflow flag, irq and wdt_rst are all 0.
- R2: Mode bits [2:0] hold the rate and mode bit 3 assigns the prescaler. When bit 3 is 0, the timer advances once every 2^(rate+1) source events: 000 gives 1:2 and 111 gives 1:256.
- R3: When mode bit 3 is 1, the timer advances on every source event. The watchdog then advances once every 2^rate ticks: 000 gives 1:1 and 111 gives 1:128.
- R4: When mode bit 5 is 0, the timer's source is cyc_en. When bit 5 is 1, the source is edges on ext_pin, and cyc_en has no effect on the count.
- R5: When mode bit 4 is 0, only rising edges of ext_pin count. When bit 4 is 1, only falling edges count. A pin change driven before clock edge k shows in the count after edge k+2.
- R6: A timer advance from 0xFF to 0x00 sets ovf_flag. The flag stays set until a write to address 2 loads wr_data[0]. If a set and a write happen in the same cycle, the set wins.
- R7: irq is high exactly when ovf_flag, tmr_ie and glb_ie are all high.
- R8: The watchdog counter is WDT_W bits wide. The advance that takes it from all-ones to zero makes wdt_rst high for exactly one cycle, in the cycle after that advance.
- R9: clr_wdt clears the watchdog counter, and wins over a tick in the same cycle. When mode bit 3 is 1, clr_wdt also clears the prescaler count.
- R10: A write to address 0 loads the count and takes priority over an advance. When mode bit 3 is 0, the write also clears the prescaler count.
- R11: When mode bit 3 is 0, the watchdog advances on every wdt_tick, whatever the rate field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable, the internal timer source |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog oscillator tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 count, 1 mode, 2 overflow flag |
| wr_data | input | 8 | Write data |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| tmr_ie | input | 1 | Timer interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| count | output | 8 | Timer count |
| mode | output | 8 | Mode register |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | Watchdog timeout reset pulse |

## Verification
Due cycles:
- A count write, a mode write, an internal-clock advance and a flag change each appear in the outputs after the clock edge that samples the stimulus.
- irq is combinational on the flag, so it follows the flag with no added delay.
- An ext_pin change passes through two synchronizer flops and an edge register, so it reaches the count only after the third edge. The bench checks that the count is unchanged after two edges and has advanced after the third.
- wdt_rst rises after the edge that takes the watchdog's final tick.

The bench drives inputs and samples outputs 1 ns after each rising edge, so every check reads a settled value. During long tick runs, the bench counts each wdt_rst pulse, so an early timeout is caught as well as a late one.

// File: rtl/tmr_wdt_shared.sv
module tmr_wdt_shared #(
  parameter int WDT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       ext_pin,
  input  logic       wdt_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       clr_wdt,
  input  logic       tmr_ie,
  input  logic       glb_ie,
  output logic [7:0] count,
  output logic [7:0] mode,
  output logic       ovf_flag,
  output logic       irq,
  output logic       wdt_rst
);
  localparam int PS_W  = 3;
  localparam int PRE_W = 2 ** PS_W;

  logic [1:0]       sync;
  logic             pin_d;
  logic [PRE_W-1:0] pre_cnt;
  logic [WDT_W-1:0] wdt_cnt;

  wire [PS_W-1:0] rate     = mode[PS_W-1:0];
  wire            to_wdt   = mode[3];
  wire            fall_sel = mode[4];
  wire            pin_src  = mode[5];

  wire pin_edge = fall_sel ? (pin_d & ~sync[1]) : (sync[1] & ~pin_d);
  wire tmr_src  = pin_src ? pin_edge : cyc_en;
  wire pre_in   = to_wdt ? wdt_tick : tmr_src;

  wire [PS_W:0]  tap  = to_wdt ? {1'b0, rate} : {1'b0, rate} + 1'b1;
  wire [PRE_W:0] span = ({{PRE_W{1'b0}}, 1'b1} << tap) - 1'b1;
  wire pre_hit = pre_in && ((pre_cnt & span[PRE_W-1:0]) == span[PRE_W-1:0]);

  wire tmr_inc = to_wdt ? tmr_src : pre_hit;
  wire wdt_inc = to_wdt ? pre_hit : wdt_tick;

  wire wr_cnt  = wr_en && (wr_addr == 2'd0);
  wire wr_mode = wr_en && (wr_addr == 2'd1);
  wire wr_flag = wr_en && (wr_addr == 2'd2);
  wire pre_clr = (wr_cnt && !to_wdt) || (clr_wdt && to_wdt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      pin_d <= 1'b0;
    end else begin
      sync  <= {sync[0], ext_pin};
      pin_d <= sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= 8'hFF;
    else if (wr_mode) mode <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (pre_clr) pre_cnt <= '0;
    else if (pre_in)  pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (wr_cnt)  count <= wr_data;
    else if (tmr_inc) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    ovf_flag <= 1'b0;
    else if (tmr_inc && !wr_cnt && (&count))       ovf_flag <= 1'b1;
    else if (wr_flag)                              ovf_flag <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_cnt <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= !clr_wdt && wdt_inc && (&wdt_cnt);
      if (clr_wdt)      wdt_cnt <= '0;
      else if (wdt_inc) wdt_cnt <= wdt_cnt + 1'b1;
    end
  end

  assign irq = ovf_flag & tmr_ie & glb_ie;

  assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> (wdt_cnt == '0) && !wdt_rst);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count == $past(wr_data));

  assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_inc && !wr_cnt && count == 8'hFF) |=> ovf_flag && count == 8'h00);

  assert_pin_mode_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_src && !pin_edge && !wr_cnt && !wr_mode) |=> $stable(count));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

// File: tb/test_tmr_wdt_shared.sv
module test_tmr_wdt_shared;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 0, ext_pin = 0, wdt_tick = 0, wr_en = 0, clr_wdt = 0;
  logic tmr_ie = 0, glb_ie = 0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count, mode;
  logic ovf_flag, irq, wdt_rst;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_wdt_shared #(.WDT_W(8)) i_tmr_wdt_shared (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_wdt(clr_wdt), .tmr_ie(tmr_ie), .glb_ie(glb_ie), .count(count),
    .mode(mode), .ovf_flag(ovf_flag), .irq(irq), .wdt_rst(wdt_rst));

  // {mode, start, events, expected count, expected flag}
  localparam logic [40:0] VEC [0:5] = '{
    {8'h00, 8'h00, 16'd10,  8'h05, 1'b0},
    {8'h01, 8'h10, 16'd9,   8'h12, 1'b0},
    {8'h07, 8'h00, 16'd512, 8'h02, 1'b0},
    {8'h08, 8'hFE, 16'd3,   8'h01, 1'b1},
    {8'h02, 8'hFF, 16'd8,   8'h00, 1'b1},
    {8'h08, 8'h20, 16'd0,   8'h20, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic run(int n);
    cyc_en = 1;
    repeat (n) step();
    cyc_en = 0;
  endtask

  task automatic clear_wdt();
    clr_wdt = 1; step(); clr_wdt = 0;
  endtask

  task automatic ticks(int n, output int pulses);
    pulses = 0;
    wdt_tick = 1;
    for (int k = 0; k < n; k++) begin
      step();
      if (wdt_rst) pulses++;
    end
    wdt_tick = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    int p;
    #12; rst_n = 1; #1;
    step();
    check("R1 mode", mode, 8'hFF);
    check("R1 count", count, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 wdt_rst", wdt_rst, 0);

    foreach (VEC[i]) begin
      write(2'd2, 8'h00);
      write(2'd1, VEC[i][40:33]);
      write(2'd0, VEC[i][32:25]);
      run(int'(VEC[i][24:9]));
      check("R2/R3 vector count", count, VEC[i][8:1]);
      check("R6 vector flag", ovf_flag, VEC[i][0]);
    end

    // R10: count write clears the timer prescaler
    write(2'd1, 8'h01);
    write(2'd0, 8'h40);
    run(3);
    write(2'd0, 8'h40);
    run(3);
    check("R10 prescaler cleared", count, 8'h40);
    run(1);
    check("R10 advance after fourth", count, 8'h41);

    // R5 / R4: external pin, rising edge
    write(2'd1, 8'h28);
    write(2'd0, 8'h00);
    ext_pin = 1;
    step(); step();
    check("R5 latency two edges", count, 0);
    step();
    check("R5 rising counted", count, 1);
    run(5);
    check("R4 cyc_en ignored", count, 1);
    ext_pin = 0; repeat (5) step();
    check("R5 falling ignored", count, 1);
    write(2'd1, 8'h38);
    ext_pin = 1; repeat (5) step();
    check("R5 rising ignored in fall mode", count, 1);
    ext_pin = 0; repeat (5) step();
    check("R5 falling counted", count, 2);

    // R6 / R7
    write(2'd1, 8'h08);
    write(2'd2, 8'h00);
    write(2'd0, 8'hFF);
    run(1);
    check("R6 wrap count", count, 0);
    check("R6 wrap flag", ovf_flag, 1);
    tmr_ie = 1; glb_ie = 0; #1;
    check("R7 global off", irq, 0);
    tmr_ie = 0; glb_ie = 1; #1;
    check("R7 timer off", irq, 0);
    tmr_ie = 1; #1;
    check("R7 both on", irq, 1);
    run(3);
    check("R6 flag sticky", ovf_flag, 1);
    write(2'd2, 8'h00);
    check("R6 flag cleared", ovf_flag, 0);
    check("R7 irq follows", irq, 0);

    // R8: 1:1 watchdog
    write(2'd1, 8'h08);
    clear_wdt();
    ticks(255, p);
    check("R8 no early timeout", p, 0);
    ticks(1, p);
    check("R8 timeout pulse", p, 1);
    step();
    check("R8 single cycle", wdt_rst, 0);

    // R3: 1:2 watchdog
    write(2'd1, 8'h09);
    clear_wdt();
    ticks(511, p);
    check("R3 wdt 1:2 early", p, 0);
    ticks(1, p);
    check("R3 wdt 1:2 timeout", p, 1);

    // R9: clear resets prescaler and counter
    clear_wdt();
    ticks(1, p);
    clear_wdt();
    ticks(511, p);
    check("R9 prescaler cleared", p, 0);
    ticks(1, p);
    check("R9 timeout after clear", p, 1);
    write(2'd1, 8'h08);
    clear_wdt();
    ticks(200, p);
    clear_wdt();
    ticks(255, p);
    check("R9 counter cleared", p, 0);
    ticks(1, p);
    check("R9 counter timeout", p, 1);

    // R11: timer owns prescaler, watchdog 1:1
    write(2'd1, 8'h07);
    clear_wdt();
    ticks(255, p);
    check("R11 no early timeout", p, 0);
    ticks(1, p);
    check("R11 timeout", p, 1);

    done = 1;
    report();
  end
endmodule